// File: doc/BRIEF.md
# Striped disk array address mapper

This block converts a logical stripe-unit number into physical coordinates on an array of disks. For each request it produces the disk that holds the data unit, the stripe row, the disk that holds that row's parity, and a flag that shows whether the layout has a parity disk at all. A two-bit mode input selects one of three layouts:
- plain striping with no redundancy;
- striping with one dedicated parity disk;
- striping with parity that moves one disk to the left on each successive row.

The mapping is registered. A request presented with its valid strobe produces a result one clock later. The result stays on the outputs until the next request arrives. The number of disks and the width of the unit number are parameters. An unused mode code raises an error output and drives every coordinate field to zero.

Top module: `stripe_mapper`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high. It is low in every other cycle.
- R2: When no request is accepted, `disk_idx`, `row_num`, `parity_idx`, `parity_present` and `mode_err` keep the values of the last result.
- R3: In mode 2'b00 (plain striping), unit k maps to `disk_idx` = k mod N and `row_num` = k div N. In this mode `parity_present` = 0 and `parity_idx` = 0.
- R4: In mode 2'b01 (dedicated parity), `parity_idx` = N-1 and `parity_present` = 1. `row_num` = k div (N-1) and `disk_idx` = k mod (N-1).
- R5: In mode 2'b10 (rotating parity), `row_num` = k div (N-1) and `parity_idx` = (N-1) - (row mod N). `parity_present` = 1. With N=5, rows 0 to 4 place parity on disks 4, 3, 2, 1 and 0, and the cycle then repeats.
- R6: In mode 2'b10, data slot s = k mod (N-1) is placed on disk s when s < `parity_idx` and on disk s+1 otherwise. As a result, a data unit never lands on the parity disk. With N=5, unit 7 goes to disk 4 in row 1.
- R7: Mode 2'b11 is invalid. For such a request `mode_err` = 1 and `disk_idx`, `row_num`, `parity_idx` and `parity_present` are all 0. `out_valid` still follows R1. `mode_err` is 0 for every valid mode.
- R8: While `rst_n` is low, and after reset until the first request, `out_valid`, `mode_err` and all coordinate fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| unit_num | input | UNIT_W | Logical stripe-unit number |
| mode | input | 2 | Layout select (00 plain, 01 dedicated parity, 10 rotating parity) |
| out_valid | output | 1 | Result strobe, one cycle after request |
| disk_idx | output | $clog2(NUM_DISKS) | Disk holding the data unit |
| row_num | output | UNIT_W | Stripe row number |
| parity_idx | output | $clog2(NUM_DISKS) | Disk holding the row's parity |
| parity_present | output | 1 | Layout has a parity disk |
| mode_err | output | 1 | Request used the invalid mode code |

## Verification
The bench sweeps consecutive units through every layout over more than one full rotation period. A design that rotated parity the wrong way, or that failed to wrap after N rows, would show a parity disk that does not match in rows 1 to 4 or in row 5. Data slots on each side of the parity disk are checked, including the slot just left of it. An off-by-one in the skip would put data on the parity disk, or it would leave disk N-1 empty. Requests are spaced with idle gaps so that a mapper that did not hold its result, or that produced its strobe a cycle late, is caught. Unit numbers near the top of the range and the invalid mode code are also applied, to expose truncated row arithmetic and leftover field values.

// File: rtl/stripe_mapper_pkg.sv
package stripe_mapper_pkg;

  typedef enum logic [1:0] {
    LAYOUT_PLAIN  = 2'b00,
    LAYOUT_FIXED  = 2'b01,
    LAYOUT_ROTATE = 2'b10,
    LAYOUT_BAD    = 2'b11
  } layout_e;

  typedef struct packed {
    logic load;
    logic selPlain;
    logic selFixed;
    logic selRotate;
    logic selBad;
  } map_ctrl_t;

endpackage

// File: rtl/stripe_mapper_ctrl.sv
module stripe_mapper_ctrl
  import stripe_mapper_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic [1:0] mode,
  output map_ctrl_t  ctrl,
  output logic       outValid
);

  layout_e layout;
  assign layout = layout_e'(mode);

  always_comb begin
    ctrl           = '0;
    ctrl.load      = inValid;
    ctrl.selPlain  = (layout == LAYOUT_PLAIN);
    ctrl.selFixed  = (layout == LAYOUT_FIXED);
    ctrl.selRotate = (layout == LAYOUT_ROTATE);
    ctrl.selBad    = (layout == LAYOUT_BAD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);   // R1
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid); // R1

endmodule

// File: rtl/stripe_mapper_dp.sv
module stripe_mapper_dp
  import stripe_mapper_pkg::*;
#(
  parameter int unsigned NUM_DISKS = 5,
  parameter int unsigned UNIT_W    = 16,
  localparam int unsigned DISK_W   = $clog2(NUM_DISKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  map_ctrl_t         ctrl,
  input  logic [UNIT_W-1:0] unitNum,
  output logic [DISK_W-1:0] diskIdx,
  output logic [UNIT_W-1:0] rowNum,
  output logic [DISK_W-1:0] parityIdx,
  output logic              parityPresent,
  output logic              modeErr
);

  localparam int unsigned DATA_PER_ROW = NUM_DISKS - 1;
  localparam bit          ROW_POW2     = ((DATA_PER_ROW & (DATA_PER_ROW - 1)) == 0);
  localparam int unsigned ROW_SHIFT    = $clog2(DATA_PER_ROW);

  logic [UNIT_W-1:0] plainRow;
  logic [DISK_W-1:0] plainDisk;
  logic [UNIT_W-1:0] parRow;
  logic [DISK_W-1:0] parSlot;
  logic [DISK_W-1:0] rowPhase;
  logic [DISK_W-1:0] rotParity;
  logic [DISK_W-1:0] rotDisk;

  assign plainRow  = unitNum / UNIT_W'(NUM_DISKS);
  assign plainDisk = DISK_W'(unitNum % UNIT_W'(NUM_DISKS));

  generate
    if (ROW_POW2) begin : g_row_shift
      assign parRow  = unitNum >> ROW_SHIFT;
      assign parSlot = DISK_W'(unitNum & UNIT_W'(DATA_PER_ROW - 1));
    end else begin : g_row_div
      assign parRow  = unitNum / UNIT_W'(DATA_PER_ROW);
      assign parSlot = DISK_W'(unitNum % UNIT_W'(DATA_PER_ROW));
    end
  endgenerate

  assign rowPhase  = DISK_W'(parRow % UNIT_W'(NUM_DISKS));
  assign rotParity = DISK_W'(NUM_DISKS - 1) - rowPhase;
  assign rotDisk   = (parSlot < rotParity) ? parSlot : parSlot + DISK_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      diskIdx       <= '0;
      rowNum        <= '0;
      parityIdx     <= '0;
      parityPresent <= 1'b0;
      modeErr       <= 1'b0;
    end else if (ctrl.load) begin
      diskIdx       <= '0;
      rowNum        <= '0;
      parityIdx     <= '0;
      parityPresent <= 1'b0;
      modeErr       <= ctrl.selBad;
      if (ctrl.selPlain) begin
        diskIdx <= plainDisk;
        rowNum  <= plainRow;
      end else if (ctrl.selFixed) begin
        diskIdx       <= parSlot;
        rowNum        <= parRow;
        parityIdx     <= DISK_W'(NUM_DISKS - 1);
        parityPresent <= 1'b1;
      end else if (ctrl.selRotate) begin
        diskIdx       <= rotDisk;
        rowNum        <= parRow;
        parityIdx     <= rotParity;
        parityPresent <= 1'b1;
      end
    end
  end

  AST_DATA_OFF_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    parityPresent |-> (diskIdx != parityIdx));                                   // R6
  AST_DISK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (diskIdx < DISK_W'(NUM_DISKS)) && (parityIdx < DISK_W'(NUM_DISKS)));         // R3
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    modeErr |-> (diskIdx == '0 && rowNum == '0 && parityIdx == '0 && !parityPresent)); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.load |=> ($stable(rowNum) && $stable(diskIdx) && $stable(parityIdx)));   // R2

endmodule

// File: rtl/stripe_mapper.sv
module stripe_mapper
  import stripe_mapper_pkg::*;
#(
  parameter int unsigned NUM_DISKS = 5,
  parameter int unsigned UNIT_W    = 16,
  localparam int unsigned DISK_W   = $clog2(NUM_DISKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [UNIT_W-1:0] unit_num,
  input  logic [1:0]        mode,
  output logic              out_valid,
  output logic [DISK_W-1:0] disk_idx,
  output logic [UNIT_W-1:0] row_num,
  output logic [DISK_W-1:0] parity_idx,
  output logic              parity_present,
  output logic              mode_err
);

  map_ctrl_t ctrl;

  stripe_mapper_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (in_valid),
    .mode     (mode),
    .ctrl     (ctrl),
    .outValid (out_valid)
  );

  stripe_mapper_dp #(
    .NUM_DISKS (NUM_DISKS),
    .UNIT_W    (UNIT_W)
  ) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl          (ctrl),
    .unitNum       (unit_num),
    .diskIdx       (disk_idx),
    .rowNum        (row_num),
    .parityIdx     (parity_idx),
    .parityPresent (parity_present),
    .modeErr       (mode_err)
  );

endmodule

// File: tb/stripe_mapper_tb.sv
module stripe_mapper_tb;

  localparam int N  = 5;
  localparam int UW = 16;
  localparam int DW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [UW-1:0] unit_num = '0;
  logic [1:0]    mode = 2'b00;
  logic          out_valid;
  logic [DW-1:0] disk_idx;
  logic [UW-1:0] row_num;
  logic [DW-1:0] parity_idx;
  logic          parity_present;
  logic          mode_err;

  int total = 0;
  int bad = 0;

  int eValid = 0, eDisk = 0, eRow = 0, ePar = 0, ePres = 0, eErr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stripe_mapper #(.NUM_DISKS(N), .UNIT_W(UW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .unit_num(unit_num),
    .mode(mode), .out_valid(out_valid), .disk_idx(disk_idx), .row_num(row_num),
    .parity_idx(parity_idx), .parity_present(parity_present), .mode_err(mode_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // reference model: behavioural, integer arithmetic
  task automatic model(input int m, input int k);
    int r, p, s;
    eErr = 0; eDisk = 0; eRow = 0; ePar = 0; ePres = 0;
    case (m)
      0: begin eDisk = k % N; eRow = k / N; end
      1: begin eDisk = k % (N - 1); eRow = k / (N - 1); ePar = N - 1; ePres = 1; end
      2: begin
        r = k / (N - 1); s = k % (N - 1); p = (N - 1) - (r % N);
        eRow = r; ePar = p; ePres = 1;
        eDisk = (s < p) ? s : s + 1;
      end
      default: eErr = 1;
    endcase
  endtask

  task automatic compare_all(input string ctx);
    chk({ctx, " R1 valid"}, int'(out_valid), eValid);
    chk({ctx, " R3/R4/R6/R7 disk"}, int'(disk_idx), eDisk);
    chk({ctx, " R3/R4/R5/R7 row"}, int'(row_num), eRow);
    chk({ctx, " R4/R5/R7 parity"}, int'(parity_idx), ePar);
    chk({ctx, " R3/R4/R5 present"}, int'(parity_present), ePres);
    chk({ctx, " R7 err"}, int'(mode_err), eErr);
  endtask

  // one cycle: compare current outputs, then drive next request
  task automatic step(input bit v, input int m, input int k, input string ctx);
    @(negedge clk);
    compare_all(ctx);
    in_valid = v;
    mode     = 2'(m);
    unit_num = UW'(k);
    eValid   = v;
    if (v) model(m, k); // R2: otherwise expectations hold
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      compare_all("R8 in reset");
    end
    rst_n = 1'b1;
    step(0, 0, 0, "R8 after reset");
    step(0, 0, 0, "R8 idle");
    // plain striping sweep
    for (int k = 0; k < 30; k++) step(1, 0, k, "R3 plain");
    // dedicated parity sweep with gaps
    for (int k = 0; k < 30; k++) begin
      step(1, 1, k, "R4 fixed");
      if (k % 7 == 3) begin step(0, 2, 99, "R2 gap"); step(0, 3, 5, "R2 gap"); end
    end
    // rotating parity: more than two full rotation periods
    for (int k = 0; k < 2 * N * (N - 1) + 6; k++) step(1, 2, k, "R5 R6 rotate");
    // explicit check of unit 7 in rotating mode (row 1, parity 3, disk 4)
    step(1, 2, 7, "R6 unit7");
    step(0, 2, 0, "R6 unit7");
    chk("R6 unit7 disk", int'(disk_idx), 4);
    chk("R5 unit7 parity", int'(parity_idx), 3);
    // invalid mode, then holding
    step(1, 3, 1234, "R7 bad mode");
    step(0, 0, 0, "R7 hold");
    step(0, 1, 77, "R2 hold");
    // mixed pattern with pseudo-random units and modes, near top of range
    begin
      int seed = 12345;
      for (int i = 0; i < 200; i++) begin
        seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
        step(((seed >> 3) & 3) != 0, (seed >> 7) & 3,
             (i % 5 == 0) ? (65535 - (seed % 40)) : ((seed >> 9) & 16'hffff),
             "R2 R5 R6 mixed");
      end
    end
    step(0, 0, 0, "final");
    step(0, 0, 0, "final");
    @(negedge clk);
    compare_all("final");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule